// File: doc/BRIEF.md
# PWM Output Pair Delay Stage

This block sits between a bank of PWM modulators and the output drivers and adds skew in whole master-clock periods at two levels. Every channel carries two differential pairs, called A and B, and each pair has a plus leg and a minus leg. Inside every pair, the minus leg lags the plus leg by a shared intra-pair amount. Across the two pairs of a channel, the whole B pair lags the A pair by an inter-pair amount. The two amounts add, so the B minus leg carries the sum of both.

Both amounts come from one 8-bit configuration byte. The upper three bits set the intra-pair skew and the lower five bits set the inter-pair skew. The byte can be changed only while the power-down input holds the modulators off. Any write made while power-down is low is dropped and the old value stays in place. While power-down is high, every delay stage is flushed and every output is driven low, so changing the settings cannot put a glitch on an output. The byte can be read back at any time.

Top module: `pwm_pair_skew`

## Requirements
- R1: After reset the configuration read-back is 0x00. With power-down low, every output then equals its input in the same cycle.
- R2: When `pdn` is 1 and `cfgWrEn` is 1 at a clock edge, `cfgRdData` shows `cfgWrData` from the next cycle onward.
- R3: When `pdn` is 0, a write is ignored and `cfgRdData` keeps its previous value.
- R4: With `pdn` low, each A plus output follows its input combinationally, with no delay.
- R5: With `pdn` low, each A minus output equals its input from D cycles earlier. D is config bits 7:5, in the range 0 to 7.
- R6: With `pdn` low, each B plus output equals its input from C cycles earlier. C is config bits 4:0, in the range 0 to 31.
- R7: With `pdn` low, each B minus output equals its input from C+D cycles earlier, up to 38 cycles.
- R8: A delay of 0 on any leg is a same-cycle bypass with no register stage.
- R9: While `pdn` is 1, all outputs are 0 and every delay stage is cleared. Once `pdn` falls, a delayed leg outputs 0 until inputs taken after the fall reach its tap.
- R10: The single D value applies to every channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down: enables writes, forces outputs low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Byte to write: bits 7:5 intra-pair, bits 4:0 inter-pair |
| cfgRdData | output | 8 | Current configuration byte |
| aPlusIn | input | NUM_CH | A pair plus legs, one bit per channel |
| aMinusIn | input | NUM_CH | A pair minus legs |
| bPlusIn | input | NUM_CH | B pair plus legs |
| bMinusIn | input | NUM_CH | B pair minus legs |
| aPlusOut | output | NUM_CH | A plus legs, not delayed |
| aMinusOut | output | NUM_CH | A minus legs, delayed by D |
| bPlusOut | output | NUM_CH | B plus legs, delayed by C |
| bMinusOut | output | NUM_CH | B minus legs, delayed by C+D |

## Verification
The bench targets the extreme settings: zero on both fields, and 0xFF, where the B minus leg must reach back the full 38 cycles. An off-by-one tap or a sum that wraps in too narrow a field would show up there as a stream shifted by one cycle, or as a short delay. Writes issued with power-down low are mixed into random traffic. A design that failed to gate them would change the read-back and shift every delayed leg. The cycles right after power-down falls check that stale history was flushed; a design that only gated the outputs would replay old pulses there.

// File: rtl/pwm_skew_pkg.sv
package pwm_skew_pkg;
  localparam int DIFF_W   = 3;
  localparam int CHNL_W   = 5;
  localparam int CFG_W    = DIFF_W + CHNL_W;
  localparam int DIFF_MAX = (1 << DIFF_W) - 1;
  localparam int CHNL_MAX = (1 << CHNL_W) - 1;
  localparam int SUM_MAX  = DIFF_MAX + CHNL_MAX;
  localparam int SUM_W    = $clog2(SUM_MAX + 1);
  localparam int NUM_LEGS = 4;

  // Control-to-datapath strobes
  typedef struct packed {
    logic              clearLines;
    logic [SUM_W-1:0]  diffSel;
    logic [SUM_W-1:0]  chnlSel;
    logic [SUM_W-1:0]  sumSel;
  } skewCtrl_t;

  // Leg order inside the datapath: 0 A+, 1 A-, 2 B+, 3 B-
  function automatic int legDepth(input int leg);
    case (leg)
      1:       return DIFF_MAX;
      2:       return CHNL_MAX;
      3:       return SUM_MAX;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/pwm_skew_ctrl.sv
module pwm_skew_ctrl
  import pwm_skew_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdn,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgQ,
  output skewCtrl_t        ctl
);
  logic [CFG_W-1:0] cfgReg;
  logic [DIFF_W-1:0] diffField;
  logic [CHNL_W-1:0] chnlField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgReg <= '0;
    else if (wrEn && pdn)  cfgReg <= wrData;
  end

  assign diffField = cfgReg[CFG_W-1 -: DIFF_W];
  assign chnlField = cfgReg[CHNL_W-1:0];

  always_comb begin
    ctl.clearLines = pdn;
    ctl.diffSel    = SUM_W'(diffField);
    ctl.chnlSel    = SUM_W'(chnlField);
    ctl.sumSel     = SUM_W'(diffField) + SUM_W'(chnlField);
  end

  assign cfgQ = cfgReg;
endmodule

// File: rtl/pwm_tap_line.sv
module pwm_tap_line #(
  parameter int WIDTH = 6,
  parameter int DEPTH = 7,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [DEPTH];
  logic [WIDTH-1:0] tap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else if (clear) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  // Tap 0 is the bypass; tap k reads stage k-1
  always_comb begin
    tap = din;
    for (int k = 1; k <= DEPTH; k++)
      if (sel == SEL_W'(k)) tap = stage[k-1];
  end

  assign dout = clear ? '0 : tap;
endmodule

// File: rtl/pwm_skew_datapath.sv
module pwm_skew_datapath
  import pwm_skew_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  skewCtrl_t         ctl,
  input  logic [NUM_CH-1:0] legIn  [NUM_LEGS],
  output logic [NUM_CH-1:0] legOut [NUM_LEGS]
);
  logic [SUM_W-1:0] legSel [NUM_LEGS];

  assign legSel[0] = '0;
  assign legSel[1] = ctl.diffSel;
  assign legSel[2] = ctl.chnlSel;
  assign legSel[3] = ctl.sumSel;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    if (g == 0) begin : gBypass
      assign legOut[g] = ctl.clearLines ? '0 : legIn[g];
    end else begin : gDelay
      pwm_tap_line #(
        .WIDTH (NUM_CH),
        .DEPTH (legDepth(g)),
        .SEL_W (SUM_W)
      ) u_line (
        .clk   (clk),
        .rstN  (rstN),
        .clear (ctl.clearLines),
        .din   (legIn[g]),
        .sel   (legSel[g]),
        .dout  (legOut[g])
      );
    end
  end
endmodule

// File: rtl/pwm_pair_skew.sv
module pwm_pair_skew
  import pwm_skew_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdn,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic [NUM_CH-1:0] aPlusIn,
  input  logic [NUM_CH-1:0] aMinusIn,
  input  logic [NUM_CH-1:0] bPlusIn,
  input  logic [NUM_CH-1:0] bMinusIn,
  output logic [NUM_CH-1:0] aPlusOut,
  output logic [NUM_CH-1:0] aMinusOut,
  output logic [NUM_CH-1:0] bPlusOut,
  output logic [NUM_CH-1:0] bMinusOut
);
  skewCtrl_t         ctl;
  logic [NUM_CH-1:0] legIn  [NUM_LEGS];
  logic [NUM_CH-1:0] legOut [NUM_LEGS];

  pwm_skew_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pdn    (pdn),
    .wrEn   (cfgWrEn),
    .wrData (cfgWrData),
    .cfgQ   (cfgRdData),
    .ctl    (ctl)
  );

  assign legIn[0] = aPlusIn;
  assign legIn[1] = aMinusIn;
  assign legIn[2] = bPlusIn;
  assign legIn[3] = bMinusIn;

  pwm_skew_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .legIn  (legIn),
    .legOut (legOut)
  );

  assign aPlusOut  = legOut[0];
  assign aMinusOut = legOut[1];
  assign bPlusOut  = legOut[2];
  assign bMinusOut = legOut[3];
endmodule

// File: rtl/pwm_pair_skew_checker.sv
module pwm_pair_skew_checker #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              pdn,
  input logic              cfgWrEn,
  input logic [7:0]        cfgWrData,
  input logic [7:0]        cfgRdData,
  input logic [NUM_CH-1:0] aPlusIn,
  input logic [NUM_CH-1:0] aMinusIn,
  input logic [NUM_CH-1:0] bPlusIn,
  input logic [NUM_CH-1:0] aPlusOut,
  input logic [NUM_CH-1:0] aMinusOut,
  input logic [NUM_CH-1:0] bPlusOut,
  input logic [NUM_CH-1:0] bMinusOut
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (pdn && cfgWrEn) |=> (cfgRdData == $past(cfgWrData)));

  a_r3_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    !pdn |=> $stable(cfgRdData));

  a_r4_aplus_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !pdn |-> (aPlusOut == aPlusIn));

  a_r5_one_cycle_skew: assert property (@(posedge clk) disable iff (!rstN)
    (!pdn && $past(!pdn) && $past(rstN) && cfgRdData[7:5] == 3'd1)
      |-> (aMinusOut == $past(aMinusIn)));

  a_r6_one_cycle_pair: assert property (@(posedge clk) disable iff (!rstN)
    (!pdn && $past(!pdn) && $past(rstN) && cfgRdData[4:0] == 5'd1)
      |-> (bPlusOut == $past(bPlusIn)));

  a_r9_quiet_in_pdn: assert property (@(posedge clk) disable iff (!rstN)
    pdn |-> ((aPlusOut | aMinusOut | bPlusOut | bMinusOut) == '0));
endmodule

bind pwm_pair_skew pwm_pair_skew_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pdn       (pdn),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .cfgRdData (cfgRdData),
  .aPlusIn   (aPlusIn),
  .aMinusIn  (aMinusIn),
  .bPlusIn   (bPlusIn),
  .aPlusOut  (aPlusOut),
  .aMinusOut (aMinusOut),
  .bPlusOut  (bPlusOut),
  .bMinusOut (bMinusOut)
);

// File: tb/pwm_pair_skew_bench.sv
module pwm_pair_skew_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int HIST = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdn = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [NCH-1:0] legIn  [4];
  logic [NCH-1:0] legOut [4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NCH-1:0] hist [4][HIST];
  logic [7:0] cfgModel = '0;
  string rdTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_pair_skew #(.NUM_CH(NCH)) u_pwm_pair_skew (
    .clk       (clk),
    .rstN      (rstN),
    .pdn       (pdn),
    .cfgWrEn   (wrEn),
    .cfgWrData (wrData),
    .cfgRdData (rdData),
    .aPlusIn   (legIn[0]),
    .aMinusIn  (legIn[1]),
    .bPlusIn   (legIn[2]),
    .bMinusIn  (legIn[3]),
    .aPlusOut  (legOut[0]),
    .aMinusOut (legOut[1]),
    .bPlusOut  (legOut[2]),
    .bMinusOut (legOut[3])
  );

  function automatic int legDelay(input int leg, input logic [7:0] c);
    case (leg)
      1:       return int'(c[7:5]);
      2:       return int'(c[4:0]);
      3:       return int'(c[7:5]) + int'(c[4:0]);
      default: return 0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] expLeg(input int leg);
    int d;
    d = legDelay(leg, cfgModel);
    if (pdn) return '0;
    if (d == 0) return legIn[leg];
    return hist[leg][d-1];
  endfunction

  function automatic string legTag(input int leg);
    int d;
    d = legDelay(leg, cfgModel);
    if (pdn) return "R9";
    if (d == 0) return (leg == 0) ? "R4 R8" : "R8";
    case (leg)
      1:       return "R5 R10";
      2:       return "R6";
      3:       return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic checkVal(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update at the clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      cfgModel <= '0;
      rdTag = "R1";
    end else if (wrEn) begin
      if (pdn) begin cfgModel <= wrData; rdTag = "R2"; end
      else rdTag = "R3";
    end
    for (int l = 0; l < 4; l++) begin
      if (!rstN || pdn) begin
        for (int k = 0; k < HIST; k++) hist[l][k] <= '0;
      end else begin
        for (int k = HIST-1; k > 0; k--) hist[l][k] <= hist[l][k-1];
        hist[l][0] <= legIn[l];
      end
    end
  end

  task automatic step(input logic p, input logic we, input logic [7:0] wd);
    @(negedge clk);
    pdn = p;
    wrEn = we;
    wrData = wd;
    for (int l = 0; l < 4; l++) legIn[l] = NCH'($urandom);
    #1;
    if (rstN) begin
      checkVal(rdTag, rdData, cfgModel);
      for (int l = 0; l < 4; l++)
        checkVal(legTag(l), 8'(legOut[l]), 8'(expLeg(l)));
    end
  endtask

  task automatic runCfg(input logic [7:0] c, input int n);
    step(1'b1, 1'b1, c);
    for (int i = 0; i < n; i++)
      step(1'b0, ($urandom % 8) == 0, 8'($urandom));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < 4; l++) legIn[l] = '0;
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < HIST; k++) hist[l][k] = '0;
    repeat (3) step(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkVal("R1", rdData, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    // R3: write with power-down low is dropped
    step(1'b0, 1'b1, 8'hA5);
    step(1'b0, 1'b0, 8'h00);
    checkVal("R3", rdData, 8'h00);
    // Directed corners: both extremes, unit skews, mixed
    runCfg(8'hFF, 60);
    runCfg(8'h00, 20);
    runCfg(8'h20, 20);
    runCfg(8'h01, 20);
    runCfg(8'hC6, 50);
    // R9: several cycles in power-down, then release with delays live
    repeat (5) step(1'b1, 1'b0, 8'h00);
    repeat (40) step(1'b0, 1'b0, 8'h00);
    // Random traffic with occasional power-down and writes
    for (int i = 0; i < 3000; i++)
      step(($urandom % 25) == 0, ($urandom % 6) == 0, 8'($urandom));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule